// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in front of the ALU of a five-stage, 32-bit integer pipeline and decides, for each of the two ALU operands, where the value comes from. There are three candidate sources:

- the register-file value latched with the instruction now in execute;
- the ALU result of the instruction now in the memory stage;
- the final result of the instruction now in writeback.

A later instruction therefore sees a result that an earlier one has produced but not yet written back. No register-file write has to wait for it.

The unit is purely combinational. It reads the two source register numbers out of the execute-stage instruction word. It compares each one with the destination numbers carried by the two later stages, and drives the chosen data together with a 2-bit select code per operand. The select code lets the surrounding pipeline, or a bench, see which path was taken.

Instructions that write no register carry destination zero, so they never forward. A load in the memory stage does not yet have its data, so it never forwards from there. Load-use spacing is left to software.

Top module: `fwd_ex_unit`

## Requirements
- R1: The A-side source register number is taken from bits 25..21 of the execute-stage instruction word, and the B-side number from bits 20..16. No other bits of that word affect the selection.
- R2: The A operand equals the memory-stage ALU result, with select code 2'b10, when the A source number matches the memory-stage destination, that destination is not zero, and the memory-stage opcode (bits 31..26) is not the load-word code 6'b100011.
- R3: The A operand equals the writeback result, with select code 2'b01, when the A source number matches the writeback destination, that destination is not zero, and the R2 condition does not hold.
- R4: The B operand and B select obey the rules of R2 and R3, applied to the B source number.
- R5: When both the memory-stage and writeback conditions hold for an operand, the memory-stage result is chosen (select 2'b10).
- R6: When neither condition holds, the operand equals the register-file value for that side, and the select code is 2'b00.
- R7: A memory-stage instruction whose opcode is 6'b100011 never supplies a forwarded value. The operand falls through to the writeback rule or to the register file.
- R8: A destination number of zero in either later stage never causes forwarding, even when the source field is also zero.
- R9: A select code of 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_instr | input | 32 | Instruction word in the execute stage |
| ex_rf_a | input | DW | Register-file value latched for the A source |
| ex_rf_b | input | DW | Register-file value latched for the B source |
| mem_instr | input | 32 | Instruction word in the memory stage |
| mem_dst | input | 5 | Destination register number of the memory-stage instruction |
| mem_alu | input | DW | ALU result held in the memory stage |
| wb_dst | input | 5 | Destination register number of the writeback instruction |
| wb_val | input | DW | Result being written back |
| op_a | output | DW | Selected ALU operand A |
| op_b | output | DW | Selected ALU operand B |
| sel_a | output | 2 | Source chosen for A: 00 register file, 01 writeback, 10 memory stage |
| sel_b | output | 2 | Source chosen for B, same encoding |

## Verification
The unit holds no state, so any wrong decision inside it appears on `sel_a`/`sel_b` and on the operand data in the same cycle as the offending input combination. Errors of this kind include:

- a swapped field slice;
- a missing zero-destination guard;
- an inverted priority;
- a load that is not blocked.

The dangerous mistakes only show when the stages collide in specific ways. These are both later stages naming the same register, a load in memory shadowing a writeback match, and source fields of zero. The stimulus therefore squeezes register numbers into a small range, so that such collisions are frequent, and checks both the select code and the data behind it.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int IW       = 32;
    localparam int RW       = 5;
    localparam int OPW      = 6;
    localparam int OP_LSB   = 26;
    localparam int RS_LSB   = 21;
    localparam int RT_LSB   = 16;
    localparam logic [OPW-1:0] OP_LOADW = 6'b100011;
    localparam int NSRC     = 2;

    typedef logic [RW-1:0] regno_t;

    typedef enum logic [1:0] {
        PICK_RF  = 2'b00,
        PICK_WB  = 2'b01,
        PICK_MEM = 2'b10
    } pick_e;

    typedef struct packed {
        regno_t dst;
        logic   can_fwd;
    } late_stage_t;

    function automatic pick_e choose_path(regno_t src,
                                          late_stage_t near_st,
                                          late_stage_t far_st);
        pick_e p;
        p = PICK_RF;
        if (far_st.can_fwd && (far_st.dst == src))
            p = PICK_WB;
        if (near_st.can_fwd && (near_st.dst == src))
            p = PICK_MEM;
        return p;
    endfunction

endpackage

// File: rtl/fwd_field_split.sv
module fwd_field_split
    import fwd_pkg::*;
(
    input  logic [IW-1:0] ex_instr,
    input  logic [IW-1:0] mem_instr,
    input  regno_t        mem_dst,
    input  regno_t        wb_dst,
    output regno_t        src_no [NSRC],
    output late_stage_t   near_st,
    output late_stage_t   far_st
);
    logic [OPW-1:0] mem_op;
    logic           mem_is_load;

    assign src_no[0]   = ex_instr[RS_LSB +: RW];
    assign src_no[1]   = ex_instr[RT_LSB +: RW];
    assign mem_op      = mem_instr[OP_LSB +: OPW];
    assign mem_is_load = (mem_op == OP_LOADW);

    always_comb begin
        near_st.dst     = mem_dst;
        near_st.can_fwd = (mem_dst != '0) && !mem_is_load;
        far_st.dst      = wb_dst;
        far_st.can_fwd  = (wb_dst != '0);
    end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
(
    input  regno_t      src_no [NSRC],
    input  late_stage_t near_st,
    input  late_stage_t far_st,
    output pick_e       pick [NSRC]
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign pick[i] = choose_path(src_no[i], near_st, far_st);
    end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  pick_e         pick,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] near_val,
    input  logic [DW-1:0] far_val,
    output logic [DW-1:0] out_val
);
    always_comb begin
        unique case (pick)
            PICK_MEM: out_val = near_val;
            PICK_WB:  out_val = far_val;
            default:  out_val = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_ex_unit.sv
module fwd_ex_unit
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [31:0]   ex_instr,
    input  logic [DW-1:0] ex_rf_a,
    input  logic [DW-1:0] ex_rf_b,
    input  logic [31:0]   mem_instr,
    input  logic [4:0]    mem_dst,
    input  logic [DW-1:0] mem_alu,
    input  logic [4:0]    wb_dst,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] op_a,
    output logic [DW-1:0] op_b,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b
);
    regno_t        src_no [NSRC];
    late_stage_t   near_st;
    late_stage_t   far_st;
    pick_e         pick [NSRC];
    logic [DW-1:0] rf_vals [NSRC];
    logic [DW-1:0] opnd [NSRC];

    assign rf_vals[0] = ex_rf_a;
    assign rf_vals[1] = ex_rf_b;

    fwd_field_split u_split (
        .ex_instr  (ex_instr),
        .mem_instr (mem_instr),
        .mem_dst   (mem_dst),
        .wb_dst    (wb_dst),
        .src_no    (src_no),
        .near_st   (near_st),
        .far_st    (far_st)
    );

    fwd_select u_sel (
        .src_no  (src_no),
        .near_st (near_st),
        .far_st  (far_st),
        .pick    (pick)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_mux
        fwd_operand_mux #(.DW(DW)) u_mux (
            .pick     (pick[i]),
            .rf_val   (rf_vals[i]),
            .near_val (mem_alu),
            .far_val  (wb_val),
            .out_val  (opnd[i])
        );
    end

    assign op_a  = opnd[0];
    assign op_b  = opnd[1];
    assign sel_a = pick[0];
    assign sel_b = pick[1];
endmodule

// File: rtl/fwd_ex_unit_chk.sv
module fwd_ex_unit_chk #(
    parameter int DW = 32
) (
    input logic [31:0]   ex_instr,
    input logic [DW-1:0] ex_rf_a,
    input logic [DW-1:0] ex_rf_b,
    input logic [31:0]   mem_instr,
    input logic [4:0]    mem_dst,
    input logic [DW-1:0] mem_alu,
    input logic [4:0]    wb_dst,
    input logic [DW-1:0] wb_val,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b
);
    always_comb begin
        AST_SEL_LEGAL: assert (sel_a != 2'b11 && sel_b != 2'b11); // R9
        AST_RF_DATA: assert (!(sel_a == 2'b00 && sel_b == 2'b00) || (op_a == ex_rf_a && op_b == ex_rf_b)); // R6
        AST_MEM_NZ: assert (!(sel_a == 2'b10 || sel_b == 2'b10) || mem_dst != 5'd0); // R8
        AST_WB_NZ: assert (!(sel_a == 2'b01 || sel_b == 2'b01) || wb_dst != 5'd0); // R8
        AST_NO_LOAD_FWD: assert (!(sel_a == 2'b10 || sel_b == 2'b10) || mem_instr[31:26] != 6'b100011); // R7
        AST_A_MEM_MATCH: assert (sel_a != 2'b10 || (ex_instr[25:21] == mem_dst && op_a == mem_alu)); // R2
        AST_A_WB_MATCH: assert (sel_a != 2'b01 || (ex_instr[25:21] == wb_dst && op_a == wb_val)); // R3
        AST_B_MEM_MATCH: assert (sel_b != 2'b10 || (ex_instr[20:16] == mem_dst && op_b == mem_alu)); // R4
    end
endmodule

bind fwd_ex_unit fwd_ex_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_fwd_ex_unit.sv
module sim_fwd_ex_unit;
    localparam int DW = 32;
    localparam logic [DW-1:0] RFA = 32'hAAAA_0001;
    localparam logic [DW-1:0] RFB = 32'hBBBB_0002;
    localparam logic [DW-1:0] MEMV = 32'hCCCC_0003;
    localparam logic [DW-1:0] WBV = 32'hDDDD_0004;
    localparam int NV = 10;

    // ex_instr(32) mem_instr(32) mem_dst(5) wb_dst(5) exp_sel_a(2) exp_sel_b(2)
    localparam logic [77:0] TBL [NV] = '{
        {6'd0, 5'd3, 5'd1, 16'd0,  6'd0, 26'd0,  5'd3, 5'd0, 2'b10, 2'b00}, // R2
        {6'd0, 5'd1, 5'd3, 16'd0,  6'd0, 26'd0,  5'd3, 5'd0, 2'b00, 2'b10}, // R4 mem
        {6'd0, 5'd3, 5'd5, 16'd0,  6'd0, 26'd0,  5'd7, 5'd3, 2'b01, 2'b00}, // R3
        {6'd0, 5'd2, 5'd3, 16'd0,  6'd0, 26'd0,  5'd9, 5'd3, 2'b00, 2'b01}, // R4 wb
        {6'd0, 5'd3, 5'd3, 16'd0,  6'd0, 26'd0,  5'd3, 5'd3, 2'b10, 2'b10}, // R5
        {6'd0, 5'd3, 5'd4, 16'd0,  6'b100011, 26'd0, 5'd3, 5'd3, 2'b01, 2'b00}, // R7
        {6'd0, 5'd0, 5'd0, 16'd0,  6'd0, 26'd0,  5'd0, 5'd0, 2'b00, 2'b00}, // R8
        {6'd0, 5'd6, 5'd7, 16'd0,  6'd0, 26'd0,  5'd1, 5'd2, 2'b00, 2'b00}, // R6
        {6'd0, 5'd4, 5'd4, 16'd0,  6'b100011, 26'd0, 5'd4, 5'd0, 2'b00, 2'b00}, // R7
        {6'd0, 5'd1, 5'd2, 5'd8, 11'd0, 6'd0, 26'd0, 5'd8, 5'd8, 2'b00, 2'b00}  // R1
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0]   ex_instr, mem_instr;
    logic [4:0]    mem_dst, wb_dst;
    logic [DW-1:0] ex_rf_a, ex_rf_b, mem_alu, wb_val;
    logic [DW-1:0] op_a, op_b;
    logic [1:0]    sel_a, sel_b;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fwd_ex_unit #(.DW(DW)) u0 (
        .ex_instr (ex_instr), .ex_rf_a (ex_rf_a), .ex_rf_b (ex_rf_b),
        .mem_instr(mem_instr), .mem_dst (mem_dst), .mem_alu (mem_alu),
        .wb_dst   (wb_dst), .wb_val (wb_val),
        .op_a (op_a), .op_b (op_b), .sel_a (sel_a), .sel_b (sel_b)
    );

    function automatic logic [1:0] ref_pick(logic [4:0] src, logic [31:0] mi,
                                            logic [4:0] md, logic [4:0] wd);
        if (md != 0 && md == src && mi[31:26] != 6'b100011) return 2'b10;
        if (wd != 0 && wd == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DW-1:0] ref_val(logic [1:0] s, logic [DW-1:0] rf);
        case (s)
            2'b10:   return MEMV;
            2'b01:   return WBV;
            default: return rf;
        endcase
    endfunction

    task automatic drive(logic [31:0] ei, logic [31:0] mi, logic [4:0] md, logic [4:0] wd);
        @(posedge clk);
        ex_instr = ei; mem_instr = mi; mem_dst = md; wb_dst = wd;
        @(negedge clk);
    endtask

    task automatic check(string req, logic [1:0] es_a, logic [1:0] es_b);
        logic [DW-1:0] ea, eb;
        ea = ref_val(es_a, RFA);
        eb = ref_val(es_b, RFB);
        total++;
        if (sel_a !== es_a || sel_b !== es_b || op_a !== ea || op_b !== eb) begin
            bad++;
            $display("FAIL %s: got sel_a=%b sel_b=%b op_a=%h op_b=%h expected sel_a=%b sel_b=%b op_a=%h op_b=%h",
                     req, sel_a, sel_b, op_a, op_b, es_a, es_b, ea, eb);
        end
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        ex_instr = '0; mem_instr = '0; mem_dst = '0; wb_dst = '0;
        ex_rf_a = RFA; ex_rf_b = RFB; mem_alu = MEMV; wb_val = WBV;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R6 reset-state idle inputs", 2'b00, 2'b00);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i][77:46], TBL[i][45:14], TBL[i][13:9], TBL[i][8:4]);
            check($sformatf("R1-table row %0d", i), TBL[i][3:2], TBL[i][1:0]);
        end

        // R5 with load in memory: writeback wins for both sides
        drive({6'd0, 5'd2, 5'd2, 16'd0}, {6'b100011, 26'd0}, 5'd2, 5'd2);
        check("R5 R7 load shadow", 2'b01, 2'b01);
        // R8 zero source, zero destinations with non-load in memory
        drive({6'd0, 5'd0, 5'd3, 16'h1234}, {6'd8, 26'd0}, 5'd0, 5'd3);
        check("R8 zero dest", 2'b00, 2'b01);
        // R1 ones outside fields must not matter
        drive({6'h3F, 5'd5, 5'd6, 16'hFFFF}, 32'd0, 5'd6, 5'd5);
        check("R1 outside bits", 2'b01, 2'b10);

        for (int k = 0; k < 400; k++) begin
            logic [31:0] ei, mi;
            logic [4:0] md, wd;
            ei = $urandom;
            ei[25:21] = 5'($urandom_range(0, 3));
            ei[20:16] = 5'($urandom_range(0, 3));
            mi = $urandom;
            if ($urandom_range(0, 2) == 0) mi[31:26] = 6'b100011;
            md = 5'($urandom_range(0, 3));
            wd = 5'($urandom_range(0, 3));
            drive(ei, mi, md, wd);
            check("R2 R3 R4 R5 R9 random", ref_pick(ei[25:21], mi, md, wd),
                  ref_pick(ei[20:16], mi, md, wd));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule